// File: doc/BRIEF.md
# Speculation Confidence Score Unit

This block holds two small signed confidence counters for each entry of a per-instruction history table. One counter governs speculative invalidation and the other governs speculative downgrading. A cache controller feeds the unit with single-cycle event pulses. Each pulse carries the table index of the instruction it concerns. There are four event classes for each kind: a normal (non-speculative) coherence action, a speculative action that was taken, a detected correct prediction, and a detected false positive. The controller asks the unit, through a query index, whether each kind of speculation is currently allowed for that instruction.

Each counter moves asymmetrically. Normal coherence traffic slowly raises confidence. Every speculative action spends a little of it. A false positive removes a large amount at once. A confirmed correct prediction restores some confidence: more for invalidation than for downgrading. The counters live in a flop array that is read, modified and written in a single cycle. The array is built from one bank per kind, and each bank holds one saturating entry per table index.

Each counter is a single register. It moves only on the clock edge that samples an event, and it has no multi-cycle sequencing. Each entry behaves as an implicit state machine over its score value. There are two named regions. ENABLED covers scores from 0 to +15. DISABLED covers scores from −16 to −1. The transitions are RAISE (normal action or correct prediction), SPEND (speculative action), PENALISE (false positive) and HOLD (no event at the entry). Any mix of these events in one cycle is folded into one combined step.

Top module: `scu_conf_unit`

## Requirements
- R1: After reset every score of both kinds is zero, so both enables read 1 for every index.
- R2: `inv_en` and `dng_en` report whether the score of the entry named by `qry_idx` is zero or greater. The score is 5-bit two's complement, so the enable is the inverse of bit 4. The read is combinational and shows an event's effect from the clock edge that sampled it.
- R3: A normal invalidation or normal downgrade pulse adds 1 to the matching score of the tagged entry.
- R4: A speculative-action-taken pulse subtracts 1 from the matching score of the tagged entry.
- R5: A false-positive pulse subtracts 8 from the matching score. From the maximum score, two consecutive false positives turn that kind off.
- R6: A correct-prediction pulse adds 4 to the invalidation score but only 1 to the downgrade score.
- R7: Invalidation and downgrade scores update independently. Entries that receive no event keep their scores.
- R8: When several events hit the same entry and kind in one cycle, their deltas are summed before saturation is applied.
- R9: Scores saturate at +15 and −16 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_norm_vld | input | 1 | Normal invalidation event |
| inv_norm_idx | input | IDX_W | Entry of the normal invalidation |
| inv_spec_vld | input | 1 | Speculative invalidation taken |
| inv_spec_idx | input | IDX_W | Entry of the speculative invalidation |
| inv_good_vld | input | 1 | Correct invalidation prediction detected |
| inv_good_idx | input | IDX_W | Entry of the correct prediction |
| inv_fp_vld | input | 1 | Invalidation false positive detected |
| inv_fp_idx | input | IDX_W | Entry of the false positive |
| dng_norm_vld | input | 1 | Normal downgrade event |
| dng_norm_idx | input | IDX_W | Entry of the normal downgrade |
| dng_spec_vld | input | 1 | Speculative downgrade taken |
| dng_spec_idx | input | IDX_W | Entry of the speculative downgrade |
| dng_good_vld | input | 1 | Correct downgrade prediction detected |
| dng_good_idx | input | IDX_W | Entry of the correct prediction |
| dng_fp_vld | input | 1 | Downgrade false positive detected |
| dng_fp_idx | input | IDX_W | Entry of the false positive |
| qry_idx | input | IDX_W | Entry whose enables are reported |
| inv_en | output | 1 | Speculative invalidation allowed for `qry_idx` |
| dng_en | output | 1 | Speculative downgrading allowed for `qry_idx` |

## Verification
The hardest situations to reach from the ports are the saturation corners combined with same-cycle collisions. The only observable output is a sign bit, so a score pinned at +15 or −16 looks the same as a score a few steps away from the bound. The stimulus first drives one entry hard into each bound with long runs of a single event class. It then walks the score back across zero with a counted number of opposite steps, so that the exact crossing cycle exposes any wrap or missing clamp. Random phases then confine event indices to four entries, which makes several event classes land on the same entry in the same cycle.

// File: rtl/scu_pkg.sv
package scu_pkg;
    // Fixed unit steps of the confidence counters
    localparam int SCU_NORM_STEP = 1;
    localparam int SCU_SPEC_STEP = 1;

    // Score kind served by one bank
    typedef enum logic {
        KIND_INV = 1'b0,
        KIND_DNG = 1'b1
    } scu_kind_e;
endpackage

// File: rtl/scu_entry.sv
module scu_entry
    import scu_pkg::*;
#(
    parameter int SCORE_W = 5,
    parameter int REWARD  = 4,
    parameter int PENALTY = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_norm,
    input  logic                      ev_spec,
    input  logic                      ev_good,
    input  logic                      ev_fp,
    output logic signed [SCORE_W-1:0] score
);
    localparam int SUM_W = SCORE_W + 6;
    localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((1 << (SCORE_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] S_MIN = SUM_W'(-(1 << (SCORE_W-1)));

    logic signed [SCORE_W-1:0] score_q;
    logic signed [SUM_W-1:0]   sum;
    logic signed [SCORE_W-1:0] score_d;

    // All deltas are folded into one sum, then clamped once
    always_comb begin
        sum = SUM_W'(score_q);
        if (ev_norm) sum = sum + SUM_W'(SCU_NORM_STEP);
        if (ev_spec) sum = sum - SUM_W'(SCU_SPEC_STEP);
        if (ev_good) sum = sum + SUM_W'(REWARD);
        if (ev_fp)   sum = sum - SUM_W'(PENALTY);
        if (sum > S_MAX)      score_d = SCORE_W'(S_MAX);
        else if (sum < S_MIN) score_d = SCORE_W'(S_MIN);
        else                  score_d = SCORE_W'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) score_q <= '0;
        else        score_q <= score_d;
    end

    assign score = score_q;

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_norm || ev_spec || ev_good || ev_fp) |=> $stable(score_q));

    a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (score_q == SCORE_W'(S_MAX) && !ev_spec && !ev_fp) |=> score_q == SCORE_W'(S_MAX));

    a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (score_q == SCORE_W'(S_MIN) && !ev_norm && !ev_good) |=> score_q == SCORE_W'(S_MIN));

    a_r5_fp_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fp |=> (score_q < $past(score_q) || $past(score_q) == SCORE_W'(S_MIN)));

    a_r3_norm_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_norm && !ev_spec && !ev_fp) |=>
            (score_q > $past(score_q) || $past(score_q) == SCORE_W'(S_MAX)));
endmodule

// File: rtl/scu_score_bank.sv
module scu_score_bank
    import scu_pkg::*;
#(
    parameter scu_kind_e KIND    = KIND_INV,
    parameter int        IDX_W   = 4,
    parameter int        SCORE_W = 5,
    parameter int        REWARD  = 4,
    parameter int        PENALTY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             norm_vld,
    input  logic [IDX_W-1:0] norm_idx,
    input  logic             spec_vld,
    input  logic [IDX_W-1:0] spec_idx,
    input  logic             good_vld,
    input  logic [IDX_W-1:0] good_idx,
    input  logic             fp_vld,
    input  logic [IDX_W-1:0] fp_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             en
);
    localparam int N_ENT = 1 << IDX_W;

    logic signed [SCORE_W-1:0] score_w [N_ENT];

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic hit_norm, hit_spec, hit_good, hit_fp;
        assign hit_norm = norm_vld && (norm_idx == IDX_W'(e));
        assign hit_spec = spec_vld && (spec_idx == IDX_W'(e));
        assign hit_good = good_vld && (good_idx == IDX_W'(e));
        assign hit_fp   = fp_vld   && (fp_idx   == IDX_W'(e));

        scu_entry #(
            .SCORE_W (SCORE_W),
            .REWARD  (REWARD),
            .PENALTY (PENALTY)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_norm (hit_norm),
            .ev_spec (hit_spec),
            .ev_good (hit_good),
            .ev_fp   (hit_fp),
            .score   (score_w[e])
        );
    end

    // Enabled while the selected score is non-negative
    assign en = !score_w[qry_idx][SCORE_W-1];

    a_r1_reset_enabled: assert property (@(posedge clk)
        !rst_n |-> en);

    if (KIND == KIND_DNG) begin : g_kind_chk
        a_r6_dng_small_reward: assert property (@(posedge clk) disable iff (!rst_n)
            (REWARD < PENALTY));
    end
endmodule

// File: rtl/scu_conf_unit.sv
module scu_conf_unit
    import scu_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int SCORE_W    = 5,
    parameter int INV_REWARD = 4,
    parameter int DNG_REWARD = 1,
    parameter int FP_PENALTY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_norm_vld,
    input  logic [IDX_W-1:0] inv_norm_idx,
    input  logic             inv_spec_vld,
    input  logic [IDX_W-1:0] inv_spec_idx,
    input  logic             inv_good_vld,
    input  logic [IDX_W-1:0] inv_good_idx,
    input  logic             inv_fp_vld,
    input  logic [IDX_W-1:0] inv_fp_idx,
    input  logic             dng_norm_vld,
    input  logic [IDX_W-1:0] dng_norm_idx,
    input  logic             dng_spec_vld,
    input  logic [IDX_W-1:0] dng_spec_idx,
    input  logic             dng_good_vld,
    input  logic [IDX_W-1:0] dng_good_idx,
    input  logic             dng_fp_vld,
    input  logic [IDX_W-1:0] dng_fp_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             inv_en,
    output logic             dng_en
);
    scu_score_bank #(
        .KIND (KIND_INV), .IDX_W (IDX_W), .SCORE_W (SCORE_W),
        .REWARD (INV_REWARD), .PENALTY (FP_PENALTY)
    ) u_inv_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .norm_vld (inv_norm_vld),
        .norm_idx (inv_norm_idx),
        .spec_vld (inv_spec_vld),
        .spec_idx (inv_spec_idx),
        .good_vld (inv_good_vld),
        .good_idx (inv_good_idx),
        .fp_vld   (inv_fp_vld),
        .fp_idx   (inv_fp_idx),
        .qry_idx  (qry_idx),
        .en       (inv_en)
    );

    scu_score_bank #(
        .KIND (KIND_DNG), .IDX_W (IDX_W), .SCORE_W (SCORE_W),
        .REWARD (DNG_REWARD), .PENALTY (FP_PENALTY)
    ) u_dng_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .norm_vld (dng_norm_vld),
        .norm_idx (dng_norm_idx),
        .spec_vld (dng_spec_vld),
        .spec_idx (dng_spec_idx),
        .good_vld (dng_good_vld),
        .good_idx (dng_good_idx),
        .fp_vld   (dng_fp_vld),
        .fp_idx   (dng_fp_idx),
        .qry_idx  (qry_idx),
        .en       (dng_en)
    );
endmodule

// File: tb/tb_scu_conf_unit.sv
`timescale 1ns/100ps
module tb_scu_conf_unit;
    localparam int IDX_W = 4;
    localparam int N = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inv_norm_vld = 0, inv_spec_vld = 0, inv_good_vld = 0, inv_fp_vld = 0;
    logic dng_norm_vld = 0, dng_spec_vld = 0, dng_good_vld = 0, dng_fp_vld = 0;
    logic [IDX_W-1:0] inv_norm_idx = 0, inv_spec_idx = 0, inv_good_idx = 0, inv_fp_idx = 0;
    logic [IDX_W-1:0] dng_norm_idx = 0, dng_spec_idx = 0, dng_good_idx = 0, dng_fp_idx = 0;
    logic [IDX_W-1:0] qry_idx = 0;
    logic inv_en, dng_en;

    int inv_m [N];
    int dng_m [N];
    int n_chk = 0;
    int n_fail = 0;
    int seed = 1234;

    always #2.5 clk = ~clk;

    scu_conf_unit dut (.*);

    function automatic int clampi(input int v);
        if (v > 15) return 15;
        if (v < -16) return -16;
        return v;
    endfunction

    task automatic clear_ev();
        inv_norm_vld = 0; inv_spec_vld = 0; inv_good_vld = 0; inv_fp_vld = 0;
        dng_norm_vld = 0; dng_spec_vld = 0; dng_good_vld = 0; dng_fp_vld = 0;
    endtask

    // One clock edge; model applies summed deltas then clamps (R8, R9)
    task automatic tick();
        int di [N];
        int dd [N];
        @(posedge clk);
        #1;
        for (int e = 0; e < N; e++) begin di[e] = 0; dd[e] = 0; end
        if (inv_norm_vld) di[inv_norm_idx] += 1;
        if (inv_spec_vld) di[inv_spec_idx] -= 1;
        if (inv_good_vld) di[inv_good_idx] += 4;
        if (inv_fp_vld)   di[inv_fp_idx]   -= 8;
        if (dng_norm_vld) dd[dng_norm_idx] += 1;
        if (dng_spec_vld) dd[dng_spec_idx] -= 1;
        if (dng_good_vld) dd[dng_good_idx] += 1;
        if (dng_fp_vld)   dd[dng_fp_idx]   -= 8;
        for (int e = 0; e < N; e++) begin
            inv_m[e] = clampi(inv_m[e] + di[e]);
            dng_m[e] = clampi(dng_m[e] + dd[e]);
        end
        clear_ev();
    endtask

    task automatic chk(input string req, input int idx);
        logic ei, ed;
        @(negedge clk);
        qry_idx = IDX_W'(idx);
        #1;
        ei = (inv_m[idx] >= 0);
        ed = (dng_m[idx] >= 0);
        n_chk++;
        if (inv_en !== ei || dng_en !== ed) begin
            n_fail++;
            $display("FAIL %s idx=%0d actual inv_en=%b dng_en=%b expected inv_en=%b dng_en=%b",
                     req, idx, inv_en, dng_en, ei, ed);
        end
    endtask

    task automatic sweep(input string req);
        for (int e = 0; e < N; e++) chk(req, e);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int e = 0; e < N; e++) begin inv_m[e] = 0; dng_m[e] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2: all enables high after reset
        sweep("R1");

        // R3: normal invalidation raises entry 2
        repeat (3) begin inv_norm_vld = 1; inv_norm_idx = 2; tick(); end
        chk("R3", 2);
        // R4: five speculative invalidations drive it to -2
        repeat (5) begin inv_spec_vld = 1; inv_spec_idx = 2; tick(); end
        chk("R4", 2);
        chk("R2", 2);
        // R6: invalidation reward +4 brings it back to +2
        inv_good_vld = 1; inv_good_idx = 2; tick();
        chk("R6", 2);
        // R7: other entries and the other kind untouched
        sweep("R7");

        // R9 ceiling then R5: 20 raises saturate at 15; two -8 steps cross zero
        repeat (20) begin dng_norm_vld = 1; dng_norm_idx = 5; tick(); end
        chk("R9", 5);
        dng_fp_vld = 1; dng_fp_idx = 5; tick();
        chk("R5", 5);
        dng_fp_vld = 1; dng_fp_idx = 5; tick();
        chk("R5", 5);
        // R9 floor: pin at -16, then 15 rewards of +1 reach -1, one more reaches 0
        repeat (3) begin dng_fp_vld = 1; dng_fp_idx = 5; tick(); end
        repeat (15) begin dng_good_vld = 1; dng_good_idx = 5; tick(); end
        chk("R9", 5);
        dng_good_vld = 1; dng_good_idx = 5; tick();
        chk("R9", 5);

        // R6: downgrade reward is only +1
        dng_spec_vld = 1; dng_spec_idx = 9; tick();
        chk("R6", 9);
        dng_good_vld = 1; dng_good_idx = 9; tick();
        chk("R6", 9);

        // R8: all four events on one entry in one cycle, both kinds
        inv_norm_vld = 1; inv_spec_vld = 1; inv_good_vld = 1; inv_fp_vld = 1;
        inv_norm_idx = 7; inv_spec_idx = 7; inv_good_idx = 7; inv_fp_idx = 7;
        dng_norm_vld = 1; dng_spec_vld = 1; dng_good_vld = 1; dng_fp_vld = 1;
        dng_norm_idx = 7; dng_spec_idx = 7; dng_good_idx = 7; dng_fp_idx = 7;
        tick();
        chk("R8", 7);
        sweep("R7");

        // Random collisions on a few entries (R2 R3 R4 R5 R6 R7 R8 R9)
        void'($urandom(seed));
        for (int i = 0; i < 800; i++) begin
            inv_norm_vld = ($urandom % 3) == 0; inv_norm_idx = IDX_W'($urandom % 4);
            inv_spec_vld = ($urandom % 3) == 0; inv_spec_idx = IDX_W'($urandom % 4);
            inv_good_vld = ($urandom % 5) == 0; inv_good_idx = IDX_W'($urandom % 4);
            inv_fp_vld   = ($urandom % 9) == 0; inv_fp_idx   = IDX_W'($urandom % 4);
            dng_norm_vld = ($urandom % 3) == 0; dng_norm_idx = IDX_W'($urandom % 4);
            dng_spec_vld = ($urandom % 3) == 0; dng_spec_idx = IDX_W'($urandom % 4);
            dng_good_vld = ($urandom % 4) == 0; dng_good_idx = IDX_W'($urandom % 4);
            dng_fp_vld   = ($urandom % 9) == 0; dng_fp_idx   = IDX_W'($urandom % 4);
            tick();
            chk("R8", int'($urandom % 4));
        end
        sweep("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule